// File: doc/BRIEF.md
# Multi-Domain Event Timestamp Snapshot

This block freezes the values of two time domains at one common instant whenever a correlation event occurs. The domains are a free-running local tick counter and a synchronised network time counter in nanoseconds. Both counters are generated elsewhere and arrive as inputs. The event comes from one of two sources, chosen by a mode bit. The first is an asynchronous once-per-second pulse input. The second is an internal periodic timer whose period is programmable in core clock cycles.

A small word-addressed register port sets the mode, the local timestamp format and the timer period at run time. The same port reads back the latched pair and reports whether a new snapshot has arrived since the last read. It can also return the live network time on demand, with no event involved. The local value is stored either as raw ticks or converted to nanoseconds with a fixed tick length. A read of the low word copies the snapshot into a hold buffer, so a multi-word read is never split across two events.

Top module: `evt_snapshot`

## Requirements
- R1: After reset, CTRL (address 0) reads 0, PERIOD (address 1) reads CLK_HZ, STATUS (address 2) reads 0 and reg_rvalid is low.
- R2: In pulse mode (CTRL bit0 = 0), a rising edge on pps_in passes through a two-flop synchroniser and an edge detector. The snapshot is taken on the third clock edge after pps_in rises, counting the first edge that samples it high, and uses the counter values present at that edge.
- R3: In timer mode (CTRL bit0 = 1), an event fires every PERIOD clock cycles. Any write to CTRL or PERIOD restarts the timer count from zero.
- R4: Only the selected source causes events. In timer mode pps_in has no effect, and in pulse mode the timer never fires.
- R5: One event latches the local value and the network value on the same clock edge.
- R6: With CTRL bit1 = 0 the local value is stored as raw ticks. With CTRL bit1 = 1 it is stored as ticks multiplied by TICK_NS, truncated to 64 bits. The format in force at the event applies.
- R7: STATUS bit0 is set by every event and cleared by a read of address 3. When an event and that read fall in the same cycle, the bit stays set.
- R8: A read of address 3 copies the latest snapshot into a hold buffer and returns its local low word. Addresses 4, 5 and 6 return the local high, network low and network high words of the hold buffer, which later events do not change.
- R9: A read of address 7 returns the low word of net_time at the reading clock edge and latches its high word. Address 8 then returns that latched high word.
- R10: reg_rdata is valid with reg_rvalid one cycle after reg_rd. Writes to any address other than 0 and 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pps_in | input | 1 | Asynchronous once-per-second pulse |
| local_cnt | input | 64 | Local tick counter value |
| net_time | input | 64 | Synchronised network time in nanoseconds |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |

## Verification
The assertions check the following on every cycle:
- The detected pulse edge is only ever one cycle wide.
- A silent timer never ticks.
- Both domains in a new snapshot equal the input values of the event cycle.
- Each event leaves the new-snapshot flag set.
- The hold buffer changes only on a low-word read.
- Each read gets a valid strobe.

The bench scenarios show the rest:
- The exact sampling cycle after a pulse.
- The spacing of timer snapshots across several periods, in both formats.
- That pulse-input and timer events are mutually exclusive.
- That the hold buffer survives a later event.
- The live network read.

// File: rtl/evt_snap_pkg.sv
// Shared constants and types for the event snapshot block.
// Assumes both time domains are 64 bits wide and registers are 32 bits.
package evt_snap_pkg;
    localparam int TS_W   = 64;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL       = 4'd0,
        A_PERIOD     = 4'd1,
        A_STATUS     = 4'd2,
        A_SNAP_LO_LO = 4'd3,
        A_SNAP_LO_HI = 4'd4,
        A_SNAP_NT_LO = 4'd5,
        A_SNAP_NT_HI = 4'd6,
        A_LIVE_NT_LO = 4'd7,
        A_LIVE_NT_HI = 4'd8
    } reg_addr_e;

    typedef struct packed {
        logic [TS_W-1:0] loc_ts;
        logic [TS_W-1:0] net_ts;
    } snap_t;
endpackage

// File: rtl/pps_edge_sync.sv
// Brings an asynchronous pulse into the clock domain through STAGES flops
// and emits a one-cycle strobe on its rising edge.
// Assumes the pulse stays high for more than one clock cycle.
module pps_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] sh_q;

    // first synchroniser stage
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q[0] <= 1'b0;
        else        sh_q[0] <= async_in;
    end

    for (genvar g = 1; g <= STAGES; g++) begin : g_stage
        // remaining synchroniser stages plus one history flop
        always_ff @(posedge clk) begin
            if (!rst_n) sh_q[g] <= 1'b0;
            else        sh_q[g] <= sh_q[g-1];
        end
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R2
endmodule

// File: rtl/event_timer.sv
// Periodic tick generator counting core clock cycles.
// Assumes period 0 or 1 means a tick on every cycle; restart clears the count.
module event_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic [CNT_W-1:0] period,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_q;

    assign tick = en && !restart && ((cnt_q + CNT_W'(1)) >= period);

    // cycle counter, cleared on tick, restart or when idle
    always_ff @(posedge clk) begin
        if (!rst_n || !en || restart || tick) cnt_q <= '0;
        else                                  cnt_q <= cnt_q + CNT_W'(1);
    end

    AST_TIMER_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !tick); // R4
    AST_TIMER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0)); // R3
endmodule

// File: rtl/snap_capture.sv
// Latches both time domains on one edge when an event strobe arrives,
// converting the local value to nanoseconds when asked, and keeps the
// sticky new-snapshot flag. Assumes TICK_NS is the local tick length in ns.
module snap_capture
    import evt_snap_pkg::*;
#(
    parameter int TICK_NS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            evt,
    input  logic            fmt_ns,
    input  logic            clr,
    input  logic [TS_W-1:0] loc_in,
    input  logic [TS_W-1:0] net_in,
    output snap_t           snap,
    output logic            fresh
);
    logic [TS_W-1:0] loc_conv;

    // local value in the selected format
    always_comb begin
        loc_conv = fmt_ns ? (loc_in * TS_W'(TICK_NS)) : loc_in;
    end

    // joint capture of both domains on the event edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap <= '0;
        end else if (evt) begin
            snap.loc_ts <= loc_conv;
            snap.net_ts <= net_in;
        end
    end

    // sticky flag: event wins over a clearing read
    always_ff @(posedge clk) begin
        if (!rst_n)   fresh <= 1'b0;
        else if (evt) fresh <= 1'b1;
        else if (clr) fresh <= 1'b0;
    end

    AST_SAME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (snap.net_ts == $past(net_in))); // R5
    AST_RAW_FMT: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !fmt_ns) |=> (snap.loc_ts == $past(loc_in))); // R6
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> fresh); // R7
endmodule

// File: rtl/evt_snapshot.sv
// Top of the event timestamp snapshot: register port, event source
// selection, hold buffer for torn-free reads and the live network read.
// Assumes single-cycle read and write strobes with reads answered next cycle.
module evt_snapshot
    import evt_snap_pkg::*;
#(
    parameter int CLK_HZ      = 200_000_000,
    parameter int TICK_NS     = 32,
    parameter int SYNC_STAGES = 2,
    parameter int PERIOD_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pps_in,
    input  logic [TS_W-1:0]   local_cnt,
    input  logic [TS_W-1:0]   net_time,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_rvalid
);
    localparam int HALF = TS_W / 2;

    logic                mode_timer_q;
    logic                fmt_ns_q;
    logic [PERIOD_W-1:0] period_q;
    logic                pps_rise;
    logic                tick;
    logic                evt;
    logic                restart;
    logic                snap_rd;
    snap_t               snap;
    snap_t               hold_q;
    logic                fresh;
    logic [HALF-1:0]     live_hi_q;
    logic                unused_wbits;

    assign unused_wbits = ^reg_wdata[DATA_W-1:2];
    assign restart = reg_wr && (reg_addr == A_CTRL || reg_addr == A_PERIOD);
    assign snap_rd = reg_rd && (reg_addr == A_SNAP_LO_LO);
    assign evt     = mode_timer_q ? tick : pps_rise;

    pps_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_in(pps_in), .rise(pps_rise)
    );

    event_timer #(.CNT_W(PERIOD_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .en(mode_timer_q), .restart(restart),
        .period(period_q), .tick(tick)
    );

    snap_capture #(.TICK_NS(TICK_NS)) cap_i (
        .clk(clk), .rst_n(rst_n), .evt(evt), .fmt_ns(fmt_ns_q), .clr(snap_rd),
        .loc_in(local_cnt), .net_in(net_time), .snap(snap), .fresh(fresh)
    );

    // control and period registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_timer_q <= 1'b0;
            fmt_ns_q     <= 1'b0;
            period_q     <= PERIOD_W'(CLK_HZ);
        end else if (reg_wr) begin
            if (reg_addr == A_CTRL) begin
                mode_timer_q <= reg_wdata[0];
                fmt_ns_q     <= reg_wdata[1];
            end else if (reg_addr == A_PERIOD) begin
                period_q <= reg_wdata[PERIOD_W-1:0];
            end
        end
    end

    // hold buffer, refreshed only by a low-word snapshot read
    always_ff @(posedge clk) begin
        if (!rst_n)       hold_q <= '0;
        else if (snap_rd) hold_q <= snap;
    end

    // registered read data and valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
            live_hi_q  <= '0;
        end else begin
            reg_rvalid <= reg_rd;
            if (reg_rd) begin
                case (reg_addr)
                    A_CTRL:       reg_rdata <= {30'd0, fmt_ns_q, mode_timer_q};
                    A_PERIOD:     reg_rdata <= DATA_W'(period_q);
                    A_STATUS:     reg_rdata <= {31'd0, fresh};
                    A_SNAP_LO_LO: reg_rdata <= snap.loc_ts[HALF-1:0];
                    A_SNAP_LO_HI: reg_rdata <= hold_q.loc_ts[TS_W-1:HALF];
                    A_SNAP_NT_LO: reg_rdata <= hold_q.net_ts[HALF-1:0];
                    A_SNAP_NT_HI: reg_rdata <= hold_q.net_ts[TS_W-1:HALF];
                    A_LIVE_NT_LO: begin
                        reg_rdata <= net_time[HALF-1:0];
                        live_hi_q <= net_time[TS_W-1:HALF];
                    end
                    A_LIVE_NT_HI: reg_rdata <= live_hi_q;
                    default:      reg_rdata <= '0;
                endcase
            end
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_rd |=> $stable(hold_q)); // R8
    AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid); // R10
endmodule

// File: tb/evt_snapshot_tb_top.sv
module evt_snapshot_tb_top;
    localparam int CLK_HZ  = 200_000_000;
    localparam int TICK_NS = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pps_in = 1'b0;
    logic [63:0] local_cnt = 64'h0000_0001_FFFF_FF00;
    logic [63:0] net_time  = 64'h0000_0007_0000_1000;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [63:0] net_at_rd;

    always #2.5 clk = ~clk;

    // free-running stimulus counters: local +1 tick, network +5 ns per cycle
    always @(posedge clk) begin
        local_cnt <= local_cnt + 64'd1;
        net_time  <= net_time + 64'd5;
    end

    evt_snapshot #(.CLK_HZ(CLK_HZ), .TICK_NS(TICK_NS)) dut_i (
        .clk(clk), .rst_n(rst_n), .pps_in(pps_in), .local_cnt(local_cnt),
        .net_time(net_time), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        net_at_rd = net_time;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
        chk("R10 rvalid", {31'd0, reg_rvalid}, 32'd1);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // pulse on pps_in; returns counters expected in the snapshot (R2)
    task automatic pulse(output logic [63:0] exp_loc, output logic [63:0] exp_net);
        @(negedge clk);
        exp_loc = local_cnt + 64'd2;
        exp_net = net_time + 64'd10;
        pps_in = 1'b1;
        repeat (4) @(negedge clk);
        pps_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_flag();
        logic [31:0] s;
        for (int i = 0; i < 400; i++) begin
            rd(4'd2, s);
            if (s[0]) return;
        end
        chk("R3 timer event seen", 32'd0, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [63:0] el, en, el2, en2;
        logic [31:0] a_loc, a_net, b_loc, b_net;
        int periods[3] = '{40, 57, 100};

        repeat (4) @(negedge clk);
        chk("R1 rvalid low", {31'd0, reg_rvalid}, 32'd0);
        rst_n = 1'b1;
        rd(4'd0, d); chk("R1 ctrl reset", d, 32'd0);
        rd(4'd1, d); chk("R1 period reset", d, 32'(CLK_HZ));
        rd(4'd2, d); chk("R1 status reset", d, 32'd0);

        // R10: status is read-only
        wr(4'd2, 32'hFFFF_FFFF);
        rd(4'd2, d); chk("R10 status write ignored", d, 32'd0);

        // R2 / R5 / R6 raw: pulse capture
        pulse(el, en);
        rd(4'd2, d); chk("R7 flag set", d, 32'd1);
        rd(4'd3, d); chk("R2 local lo", d, el[31:0]);
        rd(4'd2, d); chk("R7 flag cleared", d, 32'd0);
        rd(4'd4, d); chk("R6 local hi raw", d, el[63:32]);
        rd(4'd5, d); chk("R5 net lo", d, en[31:0]);
        rd(4'd6, d); chk("R5 net hi", d, en[63:32]);

        // R8: hold buffer survives a later event
        pulse(el2, en2);
        rd(4'd2, d); chk("R7 flag after second event", d, 32'd1);
        rd(4'd5, d); chk("R8 hold net lo unchanged", d, en[31:0]);
        rd(4'd4, d); chk("R8 hold local hi unchanged", d, el[63:32]);
        rd(4'd3, d); chk("R8 new local lo", d, el2[31:0]);
        rd(4'd5, d); chk("R8 new net lo", d, en2[31:0]);

        // R6: nanosecond format
        wr(4'd0, 32'd2);
        rd(4'd0, d); chk("R10 ctrl readback", d, 32'd2);
        pulse(el, en);
        el = el * 64'(TICK_NS);
        rd(4'd3, d); chk("R6 ns lo", d, el[31:0]);
        rd(4'd4, d); chk("R6 ns hi", d, el[63:32]);

        // R4: pulse mode never fires the timer
        wr(4'd1, 32'd20);
        wr(4'd0, 32'd0);
        repeat (100) @(negedge clk);
        rd(4'd2, d); chk("R4 no timer events in pulse mode", d, 32'd0);

        // R4: timer mode ignores the pulse
        wr(4'd1, 32'd1000);
        wr(4'd0, 32'd1);
        rd(4'd3, d);
        pulse(el, en);
        repeat (10) @(negedge clk);
        rd(4'd2, d); chk("R4 pulse ignored in timer mode", d, 32'd0);
        rd(4'd1, d); chk("R10 period readback", d, 32'd1000);

        // R3 / R6: timer spacing sweep, both formats
        for (int f = 0; f < 2; f++) begin
            for (int p = 0; p < 3; p++) begin
                wr(4'd1, 32'(periods[p]));
                wr(4'd0, {30'd0, f[0], 1'b1});
                rd(4'd3, d);
                wait_flag();
                rd(4'd3, a_loc); rd(4'd5, a_net);
                wait_flag();
                rd(4'd3, b_loc); rd(4'd5, b_net);
                chk("R3 R6 local spacing", b_loc - a_loc,
                    (f == 1) ? 32'(periods[p] * TICK_NS) : 32'(periods[p]));
                chk("R3 R5 net spacing", b_net - a_net, 32'(periods[p] * 5));
            end
        end

        // R9: live network read
        rd(4'd7, d); en = net_at_rd;
        chk("R9 live lo", d, en[31:0]);
        rd(4'd8, d); chk("R9 live hi", d, en[63:32]);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule